// File: doc/BRIEF.md
# External Pulse-Per-Second Time Alignment Unit

This unit watches an external time-of-day source made of a 48-bit seconds word and a once-per-second pulse. Each rising edge of the pulse is brought into the local clock domain through a two-flop synchroniser and turned into one internal event. At that event the unit can ask the local time counter to jump to a new value. The seconds value comes either from the external bus or from a software-held word, chosen by a 2-bit mode. The nanoseconds field starts at zero. A signed offset in units of 2^-16 ns is added, and it borrows a second when the offset is negative.

On the same event the unit latches the local counter's time together with the external seconds. One cycle later it produces a signed, saturating 32-bit error in 2^-16 ns between the two. It also raises a one-cycle interrupt event and, if enabled, a snapshot strobe for the timers. The running counter and the register bus sit outside the unit: the counter takes the overwrite request, and the bus reads the error and the registered external seconds.

Top module: `ext_pps_align`

## Requirements
- R1: `pps_in` passes through a two-flop synchroniser. A rising edge is detected only after a low-to-high transition. `pps_irq` goes high for exactly one cycle, right after the third rising clock edge at which `pps_in` is sampled high. A level held high gives no further events.
- R2: With `ow_mode` equal to 2'b00 (hold) or 2'b11 (reserved), `ow_valid` stays low. A request is made only for modes 2'b01 and 2'b10.
- R3: With `ow_mode` = 2'b01, `ow_valid` pulses together with `pps_irq`. The seconds source is `ext_sec` as sampled at the detection cycle.
- R4: With `ow_mode` = 2'b10, `ow_valid` pulses together with `pps_irq`. The seconds source is `sw_sec`.
- R5: Let o = floor(`ofs_frac` / 65536), where `ofs_frac` is a signed 32-bit value in 2^-16 ns. If o >= 0, then `ow_ns` = o and `ow_sec` = source. If o < 0, then `ow_ns` = 1_000_000_000 + o and `ow_sec` = source - 1, modulo 2^48.
- R6: `diff_valid` pulses one cycle after `pps_irq`. `diff` = ((ext_sec - loc_sec) * 1e9 - loc_ns) * 65536, signed. It uses the values sampled at the detection cycle.
- R7: `diff` saturates at 0x7FFFFFFF and 0x80000000 instead of wrapping. This includes seconds gaps larger than one second.
- R8: `snap_req` pulses together with `pps_irq` only when `snap_en` is 1 at the detection cycle.
- R9: While `tod_en` is 0, a pulse produces no `pps_irq`, `ow_valid`, `snap_req` or `diff_valid`.
- R10: `ext_sec_q` equals `ext_sec` delayed by one clock.
- R11: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tod_en | input | 1 | External time bus enable |
| snap_en | input | 1 | Allow a snapshot strobe on each pulse |
| ow_mode | input | 2 | Overwrite source: 0 hold, 1 external, 2 software, 3 reserved |
| pps_in | input | 1 | External pulse-per-second, asynchronous |
| ext_sec | input | 48 | External bus seconds |
| sw_sec | input | 48 | Software seconds value |
| ofs_frac | input | 32 | Signed offset in 2^-16 ns |
| loc_sec | input | 48 | Local counter seconds |
| loc_ns | input | 30 | Local counter nanoseconds |
| ow_valid | output | 1 | Overwrite request pulse |
| ow_sec | output | 48 | Seconds to load |
| ow_ns | output | 30 | Nanoseconds to load |
| diff | output | 32 | Signed saturating error in 2^-16 ns |
| diff_valid | output | 1 | New error value pulse |
| snap_req | output | 1 | Timer snapshot strobe |
| pps_irq | output | 1 | Pulse interrupt event |
| ext_sec_q | output | 48 | Registered external seconds |

## Verification
A stuck or skipped synchroniser stage moves `pps_irq` off its cycle at the very first pulse. A broken edge detector repeats the event and shows a second `pps_irq` one cycle later. A wrong mode decode or a wrong offset borrow shows up on `ow_sec`/`ow_ns` in the same cycle as the interrupt. A stale capture register or a wrapped difference shows on `diff` one cycle later. Pulses driven with the enable low must leave every output pulse silent.

// File: rtl/ext_pps_align_pkg.sv
package ext_pps_align_pkg;
  typedef enum logic [1:0] {
    OW_HOLD = 2'd0,
    OW_EXT  = 2'd1,
    OW_SW   = 2'd2,
    OW_RSVD = 2'd3
  } ow_mode_e;

  localparam int unsigned NS_PER_SEC = 1_000_000_000;
endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic pps_i,
  output logic evt_o
);
  logic meta_q, sync_q, prev_q;
  logic meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = pps_i;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign evt_o = en_i & sync_q & ~prev_q;

  assert_edge_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o);
endmodule

// File: rtl/pps_ow_calc.sv
module pps_ow_calc
  import ext_pps_align_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int OFS_W  = 32,
  parameter int FRAC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic [1:0]       mode_i,
  input  logic [SEC_W-1:0] ext_sec_i,
  input  logic [SEC_W-1:0] sw_sec_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             ow_vld_o,
  output logic [SEC_W-1:0] ow_sec_o,
  output logic [NS_W-1:0]  ow_ns_o
);
  localparam int ONS_W = OFS_W - FRAC_W;
  localparam logic [NS_W-1:0] SEC_NS = NS_W'(NS_PER_SEC);

  logic signed [ONS_W-1:0] ofs_ns;
  logic             take;
  logic [SEC_W-1:0] src_sec, sec_d, sec_q;
  logic [NS_W-1:0]  ns_d, ns_q;
  logic             vld_d, vld_q;

  // Upper bits of a two's complement value give floor division by 2^FRAC_W.
  assign ofs_ns = $signed(ofs_i[OFS_W-1:FRAC_W]);

  always_comb begin
    take    = 1'b0;
    src_sec = ext_sec_i;
    case (ow_mode_e'(mode_i))
      OW_EXT:  begin take = 1'b1; src_sec = ext_sec_i; end
      OW_SW:   begin take = 1'b1; src_sec = sw_sec_i;  end
      default: begin take = 1'b0; src_sec = ext_sec_i; end
    endcase
    if (ofs_ns < 0) begin
      sec_d = src_sec - SEC_W'(1);
      ns_d  = SEC_NS + NS_W'(ofs_ns);
    end else begin
      sec_d = src_sec;
      ns_d  = NS_W'(ofs_ns);
    end
    vld_d = evt_i & take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sec_q <= '0;
      ns_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (vld_d) begin
        sec_q <= sec_d;
        ns_q  <= ns_d;
      end
    end
  end

  assign ow_vld_o = vld_q;
  assign ow_sec_o = sec_q;
  assign ow_ns_o  = ns_q;

  assert_ns_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ow_vld_o |-> (ow_ns_o < SEC_NS));
endmodule

// File: rtl/pps_diff_calc.sv
module pps_diff_calc
  import ext_pps_align_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int DIFF_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic [SEC_W-1:0]  ext_sec_i,
  input  logic [SEC_W-1:0]  loc_sec_i,
  input  logic [NS_W-1:0]   loc_ns_i,
  output logic              dv_o,
  output logic [DIFF_W-1:0] diff_o
);
  localparam int ACC_W = 64;
  localparam logic signed [ACC_W-1:0] D_MAX = (64'sd1 <<< (DIFF_W-1)) - 64'sd1;
  localparam logic signed [ACC_W-1:0] D_MIN = -(64'sd1 <<< (DIFF_W-1));
  localparam logic signed [ACC_W-1:0] NSS   = 64'(NS_PER_SEC);

  logic [SEC_W-1:0] ext_c, loc_c;
  logic [NS_W-1:0]  ns_c;
  logic             cap_vld, dv_q;
  logic [DIFF_W-1:0] diff_d, diff_q;

  logic signed [SEC_W:0]     dsec;
  logic signed [ACC_W-1:0]   ns_tot, scaled;
  logic                      big_pos, big_neg;

  always_comb begin
    dsec    = $signed({1'b0, ext_c}) - $signed({1'b0, loc_c});
    big_pos = dsec > 1;
    big_neg = dsec < -1;
    ns_tot  = ACC_W'(dsec) * NSS - $signed(ACC_W'(ns_c));
    scaled  = ns_tot <<< FRAC_W;
    if (big_pos || scaled > D_MAX)      diff_d = D_MAX[DIFF_W-1:0];
    else if (big_neg || scaled < D_MIN) diff_d = D_MIN[DIFF_W-1:0];
    else                                diff_d = scaled[DIFF_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld <= 1'b0;
      dv_q    <= 1'b0;
      ext_c   <= '0;
      loc_c   <= '0;
      ns_c    <= '0;
      diff_q  <= '0;
    end else begin
      cap_vld <= evt_i;
      dv_q    <= cap_vld;
      if (evt_i) begin
        ext_c <= ext_sec_i;
        loc_c <= loc_sec_i;
        ns_c  <= loc_ns_i;
      end
      if (cap_vld) diff_q <= diff_d;
    end
  end

  assign dv_o   = dv_q;
  assign diff_o = diff_q;

  assert_gap_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld && big_pos) |=> (diff_o == D_MAX[DIFF_W-1:0]));
endmodule

// File: rtl/ext_pps_align.sv
module ext_pps_align #(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int OFS_W  = 32,
  parameter int DIFF_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tod_en,
  input  logic              snap_en,
  input  logic [1:0]        ow_mode,
  input  logic              pps_in,
  input  logic [SEC_W-1:0]  ext_sec,
  input  logic [SEC_W-1:0]  sw_sec,
  input  logic [OFS_W-1:0]  ofs_frac,
  input  logic [SEC_W-1:0]  loc_sec,
  input  logic [NS_W-1:0]   loc_ns,
  output logic              ow_valid,
  output logic [SEC_W-1:0]  ow_sec,
  output logic [NS_W-1:0]   ow_ns,
  output logic [DIFF_W-1:0] diff,
  output logic              diff_valid,
  output logic              snap_req,
  output logic              pps_irq,
  output logic [SEC_W-1:0]  ext_sec_q
);
  logic [1:0] rst_pipe;
  logic       rst_i_n;
  logic       evt;
  logic       irq_d, irq_q, snap_d, snap_q;
  logic [SEC_W-1:0] ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  pps_edge_sync u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .en_i  (tod_en),
    .pps_i (pps_in),
    .evt_o (evt)
  );

  pps_ow_calc #(.SEC_W(SEC_W), .NS_W(NS_W), .OFS_W(OFS_W), .FRAC_W(FRAC_W)) u_ow (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .evt_i     (evt),
    .mode_i    (ow_mode),
    .ext_sec_i (ext_sec),
    .sw_sec_i  (sw_sec),
    .ofs_i     (ofs_frac),
    .ow_vld_o  (ow_valid),
    .ow_sec_o  (ow_sec),
    .ow_ns_o   (ow_ns)
  );

  pps_diff_calc #(.SEC_W(SEC_W), .NS_W(NS_W), .DIFF_W(DIFF_W), .FRAC_W(FRAC_W)) u_diff (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .evt_i     (evt),
    .ext_sec_i (ext_sec),
    .loc_sec_i (loc_sec),
    .loc_ns_i  (loc_ns),
    .dv_o      (diff_valid),
    .diff_o    (diff)
  );

  always_comb begin
    irq_d  = evt;
    snap_d = evt & snap_en;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      irq_q  <= 1'b0;
      snap_q <= 1'b0;
      ext_q  <= '0;
    end else begin
      irq_q  <= irq_d;
      snap_q <= snap_d;
      ext_q  <= ext_sec;
    end
  end

  assign pps_irq   = irq_q;
  assign snap_req  = snap_q;
  assign ext_sec_q = ext_q;

  assert_irq_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pps_irq |=> !pps_irq);
  assert_ow_modes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ow_valid |-> (pps_irq && ($past(ow_mode) == 2'd1 || $past(ow_mode) == 2'd2)));
  assert_diff_follows_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    diff_valid |-> $past(pps_irq));
  assert_snap_with_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |-> (pps_irq && $past(snap_en)));
  assert_gate_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pps_irq |-> $past(tod_en));
endmodule

// File: tb/ext_pps_align_tb_top.sv
module ext_pps_align_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tod_en = 1'b0, snap_en = 1'b0, pps_in = 1'b0;
  logic [1:0] ow_mode = 2'd0;
  logic [47:0] ext_sec = '0, sw_sec = '0, loc_sec = '0;
  logic [31:0] ofs_frac = '0;
  logic [29:0] loc_ns = '0;
  logic ow_valid, diff_valid, snap_req, pps_irq;
  logic [47:0] ow_sec, ext_sec_q;
  logic [29:0] ow_ns;
  logic [31:0] diff;

  always #2.5 clk = ~clk;

  ext_pps_align dut_i (
    .clk(clk), .rst_n(rst_n), .tod_en(tod_en), .snap_en(snap_en), .ow_mode(ow_mode),
    .pps_in(pps_in), .ext_sec(ext_sec), .sw_sec(sw_sec), .ofs_frac(ofs_frac),
    .loc_sec(loc_sec), .loc_ns(loc_ns), .ow_valid(ow_valid), .ow_sec(ow_sec),
    .ow_ns(ow_ns), .diff(diff), .diff_valid(diff_valid), .snap_req(snap_req),
    .pps_irq(pps_irq), .ext_sec_q(ext_sec_q)
  );

  typedef struct {
    bit          ow;
    logic [47:0] sec;
    logic [29:0] ns;
    bit          snap;
    logic [31:0] d;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0, events = 0;
  bit diff_pend = 0;
  logic [31:0] pend_d;
  bit prev_irq = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_diff(longint e, longint l, longint ns);
    longint ds, v;
    ds = e - l;
    if (ds > 3) ds = 3;
    if (ds < -3) ds = -3;
    v = (ds * 1000000000 - ns) * 65536;
    if (v > 64'sd2147483647) v = 64'sd2147483647;
    if (v < -64'sd2147483648) v = -64'sd2147483648;
    return v[31:0];
  endfunction

  // Monitor: pops expected items as the design produces them.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (diff_pend) begin
        chk(diff_valid == 1'b1, "R6 diff_valid", diff_valid, 1);
        chk(diff == pend_d, "R6/R7 diff", diff, pend_d);
        diff_pend = 0;
      end else if (diff_valid) begin
        chk(0, "R9 unexpected diff_valid", 1, 0);
      end
      if (pps_irq && prev_irq) chk(0, "R1 repeated pps_irq", 1, 0);
      if (ow_valid && !pps_irq) chk(0, "R2 ow_valid without irq", 1, 0);
      if (pps_irq) begin
        events++;
        if (exp_q.size() == 0) begin
          chk(0, "R9 unexpected pps_irq", 1, 0);
        end else begin
          exp_t x;
          x = exp_q.pop_front();
          chk(ow_valid == x.ow, "R2 ow_valid", ow_valid, x.ow);
          if (x.ow) begin
            chk(ow_sec == x.sec, "R3/R4/R5 ow_sec", ow_sec, x.sec);
            chk(ow_ns == x.ns, "R5 ow_ns", ow_ns, x.ns);
          end
          chk(snap_req == x.snap, "R8 snap_req", snap_req, x.snap);
          diff_pend = 1;
          pend_d = x.d;
        end
      end
      prev_irq = pps_irq;
    end
  end

  task automatic run_pulse(input bit en, input bit snap, input logic [1:0] mode,
                           input longint e, input longint s, input longint l,
                           input longint lns, input int ofs);
    exp_t x;
    int ev0;
    int ons;
    longint src;
    @(negedge clk);
    tod_en = en; snap_en = snap; ow_mode = mode;
    ext_sec = e[47:0]; sw_sec = s[47:0]; loc_sec = l[47:0]; loc_ns = lns[29:0];
    ofs_frac = ofs;
    repeat (2) @(negedge clk);
    ev0 = events;
    if (en) begin
      ons = ofs >>> 16;
      src = (mode == 2'd2) ? s : e;
      x.ow = (mode == 2'd1) || (mode == 2'd2);
      x.sec = (ons < 0) ? src[47:0] - 48'd1 : src[47:0];
      x.ns = (ons < 0) ? 30'(1000000000 + ons) : 30'(ons);
      x.snap = snap;
      x.d = exp_diff(e, l, lns);
      exp_q.push_back(x);
    end
    pps_in = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk(pps_irq == 1'b0, "R1 irq not early", pps_irq, 0);
    @(posedge clk); #1;
    chk(pps_irq == en, "R1/R9 irq latency", pps_irq, en);
    repeat (4) @(negedge clk);
    pps_in = 1'b0;
    repeat (6) @(negedge clk);
    if (!en) chk(events == ev0, "R9 no event when disabled", events - ev0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs zero in reset
    chk({ow_valid, diff_valid, snap_req, pps_irq} == 4'b0, "R11 reset pulses",
        {ow_valid, diff_valid, snap_req, pps_irq}, 0);
    chk(ow_sec == 0 && ow_ns == 0 && diff == 0 && ext_sec_q == 0, "R11 reset data", diff, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R10: external seconds registered one cycle
    ext_sec = 48'hABCD_0000_1234;
    @(posedge clk); #1;
    chk(ext_sec_q == 48'hABCD_0000_1234, "R10 ext_sec_q", ext_sec_q, 48'hABCD_0000_1234);

    run_pulse(1, 0, 2'd1, 1000, 7, 999, 999999990, 0);                  // R3, R6
    run_pulse(1, 1, 2'd2, 500, 48'h1234_5678_9ABC, 500, 20, 10*65536+123); // R4, R5, R8
    run_pulse(1, 0, 2'd1, 1, 3, 0, 999999999, -5*65536);               // R5 borrow
    run_pulse(1, 1, 2'd0, 105, 3, 100, 0, 0);                          // R2 hold, R7 pos sat
    run_pulse(1, 0, 2'd3, 500, 3, 500, 500000, 0);                     // R2 reserved, R7 neg sat
    run_pulse(0, 1, 2'd1, 42, 3, 42, 0, 0);                            // R9 disabled
    run_pulse(1, 0, 2'd2, 9, 0, 9, 0, -1);                             // R5 wrap of seconds
    run_pulse(1, 0, 2'd1, 10, 3, 12, 0, 0);                            // R7 large negative gap
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all events seen", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule